// File: doc/BRIEF.md
# Zero-Terminated String Emitter

This block walks a word-addressed memory from a given start address and sends the characters it finds out on a byte-wide stream with a valid/ready handshake. A processor uses it to service a "print string" trap. The start address is the value held in general register 0 when the trap is taken. The walk reads one word at a time at increasing addresses and ends at the first word equal to zero. The zero word itself sends nothing. When the walk ends, a one-cycle completion pulse is raised.

There are two character layouts, selected when the engine starts. In single mode each nonzero word supplies one character, taken from its low byte. In dual mode each nonzero word supplies its low byte first and its high byte second. The high byte is dropped when it is zero. Only a whole zero word ends the string. The memory read port has a latency of one cycle: the data for a request made in one cycle is on `mem_rdata_i` in the next cycle.

The controller has six states. IDLE waits for a start request. FETCH issues a read. WAIT captures the returned word. LOW offers the low byte. HIGH offers the high byte. FIN raises the completion pulse. The transitions are:
- IDLE→FETCH on start.
- FETCH→WAIT always.
- WAIT→FIN when the word is zero, and WAIT→LOW otherwise.
- LOW→HIGH on acceptance in dual mode with a nonzero high byte.
- LOW→FETCH on any other acceptance.
- HIGH→FETCH on acceptance.
- FIN→IDLE always.

Top module: `str_emit`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o`, `done_o` and `mem_req_o` are all 0.
- R2: A start request in IDLE latches `base_addr_i` and `dual_i`. The cycle after the start edge shows `mem_req_o`=1 with `mem_addr_o` equal to the latched base.
- R3: Successive reads use addresses base, base+1, base+2 and so on, modulo 2^ADDR_W, so 0xFFFF is followed by 0x0000.
- R4: A returned word of 0x0000 ends the walk and sends no character. The completion pulse appears in the cycle after that word is returned.
- R5: With `dual_i`=0, each nonzero word sends exactly one character, equal to bits [7:0]. Bits [15:8] are ignored.
- R6: With `dual_i`=1, each nonzero word sends bits [7:0] first and then bits [15:8]. The second character is omitted when bits [15:8] are zero. A zero low byte in a nonzero word is still sent as 0x00.
- R7: Once `out_valid_o` is raised, it stays high with unchanged `out_data_o` until a cycle in which `out_ready_i` is 1.
- R8: No memory read is issued while a character of the current word is still waiting on the stream (`mem_req_o` and `out_valid_o` are never both 1).
- R9: A start request while `busy_o` is 1 has no effect on the address walk, the mode or the characters sent.
- R10: `done_o` is high for exactly one cycle per walk, and `busy_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request (acted on only in IDLE) |
| dual_i | input | 1 | 1 = two characters per word, 0 = one |
| base_addr_i | input | ADDR_W | First word address (register 0 at trap time) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | WORD_W | Read data, one cycle after the request |
| out_valid_o | output | 1 | Character available |
| out_data_o | output | CHAR_W | Character value |
| out_ready_i | input | 1 | Stream sink accepts the character |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start request that arrives during a walk. It must not reload the address or the mode, even while the sink is back-pressuring the engine. The bench holds start high with a different base and the opposite mode for several cycles, with a pseudo-random ready pattern, and then checks that the characters and read addresses still match the first request. The address wrap is reached by starting two words below the top of the address space. The bench's memory model is indexed by the low address bits so that the read after 0xFFFF lands on real data.

// File: rtl/str_emit_pkg.sv
package str_emit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_LOW   = 3'd3,
        ST_HIGH  = 3'd4,
        ST_FIN   = 3'd5
    } emit_state_t;
endpackage

// File: rtl/str_addr_ctr.sv
module str_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (step_i) begin
            addr_q <= addr_q + ONE;   // natural wrap at the top of the space
        end
    end

    assign addr_o = addr_q;

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_o == $past(addr_o) + ONE));
endmodule

// File: rtl/str_word_hold.sv
module str_word_hold #(
    parameter int WORD_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CHAR_W-1:0] lo_o,
    output logic [CHAR_W-1:0] hi_o,
    output logic              hi_zero_o
);
    localparam bit HAS_HI = (WORD_W >= 2*CHAR_W);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture_i) begin
            word_q <= word_i;
        end
    end

    assign lo_o = word_q[CHAR_W-1:0];

    generate
        if (HAS_HI) begin : g_hi
            assign hi_o = word_q[2*CHAR_W-1:CHAR_W];
        end else begin : g_no_hi
            assign hi_o = '0;
        end
    endgenerate

    assign hi_zero_o = (hi_o == '0);
endmodule

// File: rtl/str_emit.sv
module str_emit
    import str_emit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dual_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    output logic [CHAR_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              busy_o,
    output logic              done_o
);
    emit_state_t       state_q, state_d;
    logic              dual_q;
    logic              launch;
    logic              word_zero;
    logic [CHAR_W-1:0] ch_lo, ch_hi;
    logic              hi_zero;
    logic [ADDR_W-1:0] addr;

    assign launch    = (state_q == ST_IDLE) && start_i;
    assign word_zero = (mem_rdata_i == '0);

    str_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (launch),
        .load_val_i (base_addr_i),
        .step_i     (state_q == ST_WAIT),
        .addr_o     (addr)
    );

    str_word_hold #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (state_q == ST_WAIT),
        .word_i    (mem_rdata_i),
        .lo_o      (ch_lo),
        .hi_o      (ch_hi),
        .hi_zero_o (hi_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dual_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) dual_q <= dual_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  state_d = word_zero ? ST_FIN : ST_LOW;
            ST_LOW: begin
                if (out_ready_i) begin
                    state_d = (dual_q && !hi_zero) ? ST_HIGH : ST_FETCH;
                end
            end
            ST_HIGH:  if (out_ready_i) state_d = ST_FETCH;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req_o   = (state_q == ST_FETCH);
        mem_addr_o  = addr;
        out_valid_o = (state_q == ST_LOW) || (state_q == ST_HIGH);
        out_data_o  = (state_q == ST_HIGH) ? ch_hi : ch_lo;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FIN);
    end

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R8
    no_read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !out_valid_o);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R4
    zero_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && word_zero) |=> done_o);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(dual_q));
endmodule

// File: tb/sim_str_emit.sv
module sim_str_emit;
    localparam int CLK_P = 10;
    localparam int MEM_N = 32;
    localparam int LOG_N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dual_i = 1'b0;
    logic [15:0] base_addr_i = '0;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic [15:0] mem_rdata_i = '0;
    logic        out_valid_o;
    logic [7:0]  out_data_o;
    logic        out_ready_i = 1'b0;
    logic        busy_o;
    logic        done_o;

    always #(CLK_P/2) clk = ~clk;

    str_emit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dual_i(dual_i),
        .base_addr_i(base_addr_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready_i), .busy_o(busy_o), .done_o(done_o)
    );

    logic [15:0] mem [MEM_N];
    always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[4:0]];

    int check_n = 0;
    int fail_n = 0;
    int got_n = 0;
    int addr_n = 0;
    int done_n = 0;
    logic [7:0]  got_c [LOG_N];
    logic [15:0] got_a [LOG_N];
    logic [7:0]  exp_c [LOG_N];
    logic [15:0] exp_a [LOG_N];
    bit          rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          prev_stall = 1'b0;
    logic [7:0]  prev_data = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        check_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", check_n - fail_n, check_n);
    endtask

    // monitor: ready generation and stream bookkeeping, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready_i = rdy_rand ? lfsr[0] : 1'b1;
            if (prev_stall) begin
                // R7
                chk(out_valid_o && out_data_o == prev_data, "R7", "held char", out_data_o, prev_data);
            end
            if (mem_req_o) begin
                // R8
                chk(!out_valid_o, "R8", "read while char pending", out_valid_o, 0);
                got_a[addr_n % LOG_N] = mem_addr_o;
                addr_n++;
            end
            if (out_valid_o && out_ready_i) begin
                got_c[got_n % LOG_N] = out_data_o;
                got_n++;
            end
            prev_stall = out_valid_o && !out_ready_i;
            prev_data  = out_data_o;
            if (done_o) done_n++;
        end
    end

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic build_exp(input logic [15:0] base, input bit dual, output int n, output int an);
        logic [15:0] a;
        logic [15:0] w;
        n = 0; an = 0; a = base;
        for (int k = 0; k < MEM_N; k++) begin
            w = mem[a[4:0]];
            exp_a[an] = a; an++;
            if (w == 16'h0000) break;
            exp_c[n] = w[7:0]; n++;
            if (dual && w[15:8] != 8'h00) begin
                exp_c[n] = w[15:8]; n++;
            end
            a = a + 16'd1;
        end
    endtask

    task automatic run_one(input logic [15:0] base, input bit dual, input bit rnd, input bit hold_start);
        int en, ean, g0, a0, d0, cyc;
        string rq;
        rq = dual ? "R6" : "R5";
        build_exp(base, dual, en, ean);
        g0 = got_n; a0 = addr_n; d0 = done_n;
        rdy_rand = rnd;
        start_i = 1'b1; base_addr_i = base; dual_i = dual;
        step();
        // R2
        chk(mem_req_o && mem_addr_o == base, "R2", "first read address", mem_addr_o, base);
        if (hold_start) begin
            // R9: conflicting request while busy
            base_addr_i = base + 16'd5;
            dual_i = ~dual;
        end else begin
            start_i = 1'b0;
        end
        cyc = 0;
        while (done_n == d0 && cyc < 3000) begin
            step();
            cyc++;
            if (cyc == 3) start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(cyc < 3000, "R10", "walk completes", cyc, 0);
        step();
        // R10
        chk(done_n - d0 == 1 && !done_o && !busy_o, "R10", "single done then idle", done_n - d0, 1);
        chk(got_n - g0 == en, hold_start ? "R9" : rq, "char count", got_n - g0, en);
        for (int i = 0; i < en && i < got_n - g0; i++) begin
            chk(got_c[(g0 + i) % LOG_N] == exp_c[i], hold_start ? "R9" : rq, "char",
                got_c[(g0 + i) % LOG_N], exp_c[i]);
        end
        // R3 / R4: address walk ends at the zero word
        chk(addr_n - a0 == ean, "R4", "read count", addr_n - a0, ean);
        for (int i = 0; i < ean && i < addr_n - a0; i++) begin
            chk(got_a[(a0 + i) % LOG_N] == exp_a[i], "R3", "read address",
                got_a[(a0 + i) % LOG_N], exp_a[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check_n++;
        fail_n++;
        $display("FAIL watchdog: actual expired expected finish");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(!busy_o && !out_valid_o && !done_o && !mem_req_o, "R1", "reset outputs",
            {busy_o, out_valid_o, done_o, mem_req_o}, 0);
        rst_n = 1'b1;
        step();
        chk(!busy_o && !out_valid_o && !done_o && !mem_req_o, "R1", "idle after reset",
            {busy_o, out_valid_o, done_o, mem_req_o}, 0);

        // single mode: high bytes must be ignored (R5)
        mem[2] = 16'h0041; mem[3] = 16'h1242; mem[4] = 16'h0043; mem[5] = 16'h0000;
        run_one(16'd2, 1'b0, 1'b0, 1'b0);
        run_one(16'd2, 1'b0, 1'b1, 1'b0);

        // dual mode: skipped zero high byte, zero low byte still sent (R6)
        mem[8] = 16'h4241; mem[9] = 16'h0043; mem[10] = 16'h4400; mem[11] = 16'h0000;
        run_one(16'd8, 1'b1, 1'b0, 1'b0);
        run_one(16'd8, 1'b1, 1'b1, 1'b0);

        // empty string (R4)
        mem[14] = 16'h0000;
        run_one(16'd14, 1'b0, 1'b0, 1'b0);
        run_one(16'd14, 1'b1, 1'b1, 1'b0);

        // address wrap (R3)
        mem[30] = 16'h0031; mem[31] = 16'h3332; mem[0] = 16'h0034; mem[1] = 16'h0000;
        run_one(16'hFFFE, 1'b0, 1'b0, 1'b0);
        run_one(16'hFFFE, 1'b1, 1'b1, 1'b0);

        // start while busy ignored (R9)
        run_one(16'd8, 1'b1, 1'b1, 1'b1);
        run_one(16'd2, 1'b0, 1'b1, 1'b1);

        // sweep over lengths, modes and ready patterns
        for (int len = 0; len <= 6; len++) begin
            for (int k = 0; k < len; k++) begin
                mem[16 + k] = {((k % 3) == 0) ? 8'h00 : 8'(8'h60 + k), 8'(8'h40 + k + len)};
            end
            mem[16 + len] = 16'h0000;
            for (int m = 0; m < 4; m++) begin
                run_one(16'd16, m[0], m[1], 1'b0);
            end
        end

        report();
        $finish;
    end
endmodule